// File: doc/BRIEF.md
# Radix-4 Butterfly Datapath (time-shared)

This block evaluates one decimation-in-time radix-4 butterfly on four complex 16-bit samples and three complex 16-bit twiddle factors. A single real multiplier and its first adder are reused for twelve consecutive clock cycles. Each cycle forms one of the four real partial products of one of the three twiddle rotations. The last two adder levels combine the four rotated points, and the minus-j rotation is done by swapping real and imaginary parts and negating one of them. A growth mode then picks sixteen bits of each 19-bit sum.

Before the multiply, every data sample is shifted left by the amount a block floating point scaler asks for. With each result the block reports two values. The first is an overflow flag. The second is the number of redundant sign bits in the largest output word, which the scaler uses in the next pass. A caller pulses `start` while the block is idle. Exactly twelve clock edges later the results appear, and `done` is high for one cycle.

Top module: `bfly_r4_core`

## Requirements
- R1: While reset is high and after it is released, `busy`, `done` and `ovf` are 0 and `dout_re`, `dout_im` and `hdrm` are all zero.
- R2: If `start` is high at a clock edge while `busy` is low, the inputs are captured and `busy` rises. The twelfth edge after that drives `done` high for exactly one cycle with the results and lowers `busy`.
- R3: A `start` pulse while `busy` is high is ignored: the current result, its timing and the captured operands are unchanged, and no extra `done` pulse follows.
- R4: Each component of each data input is shifted left by `pre_shift` bits and truncated to 16 bits before any arithmetic. Twiddles are not shifted.
- R5: Each real product of a 16-bit data component and a 16-bit twiddle component is its full 32-bit signed product arithmetically shifted right by 14, kept as 18 bits, with bit 0 forced to 1.
- R6: Rotated point k (k = 1..3) has real part (P(xr,wr) − P(xi,wi)) and imaginary part (P(xr,wi) + P(xi,wr)), each formed at 19 bits and arithmetically shifted right by 1. Point 0 bypasses the multiplier, sign-extended to 18 bits.
- R7: With y0..y3 the 18-bit points, a = (y0+y2)>>1, b = (y0−y2)>>1, c = (y1+y3)>>1 and d = (y1−y3)>>1, each at 19 bits before the shift. The 19-bit outputs are then: index 0 = a+c, index 2 = a−c, index 1 = (b.re+d.im, b.im−d.re) and index 3 = (b.re−d.im, b.im+d.re).
- R8: With `mode` = 0 (two-bit growth), each 16-bit output is bits [16:1] of its 19-bit sum. `ovf` is 1 when, for any of the eight sums, bits [18:16] are not all equal.
- R9: With `mode` = 1 (three-bit growth), each 16-bit output is bits [17:2] of its 19-bit sum, and `ovf` is 0.
- R10: `hdrm` equals the smallest, over the eight 16-bit outputs, count of bits below the MSB that equal the MSB and are contiguous with it (an all-zero word counts 15).
- R11: `dout_re`, `dout_im`, `ovf` and `hdrm` change only on the edge that raises `done`, and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a butterfly; sampled only while idle |
| mode | input | 1 | 0 = two-bit growth window, 1 = three-bit growth window |
| pre_shift | input | 2 | Left shift applied to data samples at capture |
| din_re | input | 4x16 | Real parts of the four samples, index 0..3 |
| din_im | input | 4x16 | Imaginary parts of the four samples |
| tw_re | input | 3x16 | Real parts of twiddles for samples 1..3 (Q1.15) |
| tw_im | input | 3x16 | Imaginary parts of twiddles for samples 1..3 |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle result strobe |
| dout_re | output | 4x16 | Real parts of the four outputs |
| dout_im | output | 4x16 | Imaginary parts of the four outputs |
| ovf | output | 1 | Selected window lost significant bits |
| hdrm | output | 4 | Minimum redundant sign-bit count of the outputs |

## Verification
The assertions take for granted that reset is applied before the first `start`. They also assume the caller can hold `start` high at any time, so a start during a run must leave the twelve-cycle count intact. They rely on `ovf` being impossible in the three-bit window for any 16-bit operands, twiddle components included, so the stimulus uses full-scale samples and twiddles whose two components are driven independently up to ±32767. With pre-shifts the stimulus uses samples small enough that the shift keeps their sign, which keeps the bench model and the design in the same numeric range.

// File: rtl/bfly_r4_pkg.sv
package bfly_r4_pkg;

    localparam int DW     = 16;           // data and twiddle width
    localparam int PW     = DW + 2;       // product / point width
    localparam int SW     = PW + 1;       // final sum width
    localparam int NPT    = 4;            // points per butterfly
    localparam int NTW    = NPT - 1;      // twiddled points
    localparam int PHASES = 4;            // real products per rotation
    localparam int NCYC   = NTW * PHASES; // shared-multiplier cycles
    localparam int CW     = $clog2(NCYC);
    localparam int PHW    = $clog2(PHASES);
    localparam int KW     = $clog2(NTW);
    localparam int PIW    = $clog2(NPT);
    localparam int HW     = $clog2(DW);
    localparam int PSH    = 2 * DW - PW;  // product right shift

    typedef struct packed {
        logic signed [DW-1:0] re;
        logic signed [DW-1:0] im;
    } cd_t;

    typedef struct packed {
        logic signed [PW-1:0] re;
        logic signed [PW-1:0] im;
    } cp_t;

    typedef struct packed {
        logic signed [SW-1:0] re;
        logic signed [SW-1:0] im;
    } cs_t;

    typedef enum logic {GROW2 = 1'b0, GROW3 = 1'b1} grow_e;
    typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} st_e;

    // full-precision product kept as PW bits, LSB forced high
    function automatic logic signed [PW-1:0] round_prod(
        input logic signed [DW-1:0] a, input logic signed [DW-1:0] b);
        logic signed [2*DW-1:0] f;
        logic signed [PW-1:0]   r;
        f = a * b;
        r = f[2*DW-1:PSH];
        r[0] = 1'b1;
        return r;
    endfunction

    // one-bit growth add/sub followed by dropping the LSB
    function automatic logic signed [PW-1:0] half_add(
        input logic signed [PW-1:0] a, input logic signed [PW-1:0] b, input logic sub);
        logic signed [SW-1:0] s;
        s = sub ? (SW'(a) - SW'(b)) : (SW'(a) + SW'(b));
        return s[SW-1:1];
    endfunction

    // one-bit growth add/sub, all bits kept
    function automatic logic signed [SW-1:0] wide_add(
        input logic signed [PW-1:0] a, input logic signed [PW-1:0] b, input logic sub);
        return sub ? (SW'(a) - SW'(b)) : (SW'(a) + SW'(b));
    endfunction

    function automatic logic signed [PW-1:0] sext_p(input logic signed [DW-1:0] v);
        return PW'(v);
    endfunction

    // redundant sign bits below the MSB
    function automatic logic [HW-1:0] sign_bits(input logic [DW-1:0] v);
        logic [HW-1:0] n;
        logic          run;
        n   = '0;
        run = 1'b1;
        for (int i = DW - 2; i >= 0; i--) begin
            if (run && (v[i] == v[DW-1])) n = n + 1'b1;
            else run = 1'b0;
        end
        return n;
    endfunction

endpackage

// File: rtl/bfly_r4_mac.sv
module bfly_r4_mac
    import bfly_r4_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic [CW-1:0]       step,
    input  cd_t  [NPT-1:0]      xs,
    input  cd_t  [NTW-1:0]      tw,
    output cp_t  [NTW-1:0]      y_live
);

    logic [CW-1:0]        kfull;
    logic [KW-1:0]        ki;
    logic [PIW-1:0]       xi;
    logic [PHW-1:0]       ph;
    cd_t                  xa;
    cd_t                  wb;
    logic signed [DW-1:0] op_a;
    logic signed [DW-1:0] op_b;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] comb;
    logic signed [PW-1:0] p_hold;
    cp_t  [NTW-1:0]       y_q;

    always_comb begin
        kfull = step >> PHW;
        ki    = (kfull >= CW'(NTW)) ? KW'(NTW - 1) : kfull[KW-1:0];
        xi    = PIW'(ki) + PIW'(1);
        ph    = step[PHW-1:0];
        xa    = xs[xi];
        wb    = tw[ki];
        case (ph)
            2'd0:    begin op_a = xa.re; op_b = wb.re; end
            2'd1:    begin op_a = xa.im; op_b = wb.im; end
            2'd2:    begin op_a = xa.re; op_b = wb.im; end
            default: begin op_a = xa.im; op_b = wb.re; end
        endcase
        prod = round_prod(op_a, op_b);
        comb = half_add(p_hold, prod, (ph == 2'd1));
        y_live = y_q;
        if (en && ph == 2'd1) y_live[ki].re = comb;
        if (en && ph == 2'd3) y_live[ki].im = comb;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            p_hold <= '0;
            y_q    <= '0;
        end else if (en) begin
            if (ph == 2'd0 || ph == 2'd2) p_hold <= prod;
            y_q <= y_live;
        end
    end

endmodule

// File: rtl/bfly_r4_net.sv
module bfly_r4_net
    import bfly_r4_pkg::*;
(
    input  cp_t [NPT-1:0] y,
    output cs_t [NPT-1:0] s
);

    cp_t a, b, c, d;

    always_comb begin
        a.re = half_add(y[0].re, y[2].re, 1'b0);
        a.im = half_add(y[0].im, y[2].im, 1'b0);
        b.re = half_add(y[0].re, y[2].re, 1'b1);
        b.im = half_add(y[0].im, y[2].im, 1'b1);
        c.re = half_add(y[1].re, y[3].re, 1'b0);
        c.im = half_add(y[1].im, y[3].im, 1'b0);
        d.re = half_add(y[1].re, y[3].re, 1'b1);
        d.im = half_add(y[1].im, y[3].im, 1'b1);

        s[0].re = wide_add(a.re, c.re, 1'b0);
        s[0].im = wide_add(a.im, c.im, 1'b0);
        s[2].re = wide_add(a.re, c.re, 1'b1);
        s[2].im = wide_add(a.im, c.im, 1'b1);
        // -j rotation of d: swap parts, negate the new imaginary part
        s[1].re = wide_add(b.re, d.im, 1'b0);
        s[1].im = wide_add(b.im, d.re, 1'b1);
        s[3].re = wide_add(b.re, d.im, 1'b1);
        s[3].im = wide_add(b.im, d.re, 1'b0);
    end

endmodule

// File: rtl/bfly_r4_sel.sv
module bfly_r4_sel
    import bfly_r4_pkg::*;
(
    input  cs_t  [NPT-1:0] s,
    input  grow_e          mode,
    output cd_t  [NPT-1:0] o,
    output logic           ovf,
    output logic [HW-1:0]  hdrm
);

    logic [NPT-1:0] pt_ovf;

    for (genvar g = 0; g < NPT; g++) begin : g_pt
        always_comb begin
            if (mode == GROW3) begin
                o[g].re   = s[g].re[DW+1:2];
                o[g].im   = s[g].im[DW+1:2];
                pt_ovf[g] = (^s[g].re[SW-1:SW-2]) | (^s[g].im[SW-1:SW-2]);
            end else begin
                o[g].re   = s[g].re[DW:1];
                o[g].im   = s[g].im[DW:1];
                pt_ovf[g] = ~((&s[g].re[SW-1:DW]) | ~(|s[g].re[SW-1:DW]))
                          | ~((&s[g].im[SW-1:DW]) | ~(|s[g].im[SW-1:DW]));
            end
        end
    end

    always_comb begin
        ovf  = |pt_ovf;
        hdrm = HW'(DW - 1);
        for (int i = 0; i < NPT; i++) begin
            if (sign_bits(o[i].re) < hdrm) hdrm = sign_bits(o[i].re);
            if (sign_bits(o[i].im) < hdrm) hdrm = sign_bits(o[i].im);
        end
    end

endmodule

// File: rtl/bfly_r4_core.sv
module bfly_r4_core
    import bfly_r4_pkg::*;
#(
    parameter int SHIFT_W = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic                      mode,
    input  logic [SHIFT_W-1:0]        pre_shift,
    input  logic [NPT-1:0][DW-1:0]    din_re,
    input  logic [NPT-1:0][DW-1:0]    din_im,
    input  logic [NTW-1:0][DW-1:0]    tw_re,
    input  logic [NTW-1:0][DW-1:0]    tw_im,
    output logic                      busy,
    output logic                      done,
    output logic [NPT-1:0][DW-1:0]    dout_re,
    output logic [NPT-1:0][DW-1:0]    dout_im,
    output logic                      ovf,
    output logic [HW-1:0]             hdrm
);

    st_e               state;
    logic [CW-1:0]     cnt;
    cd_t  [NPT-1:0]    xs_q;
    cd_t  [NTW-1:0]    tw_q;
    grow_e             mode_q;
    cp_t  [NTW-1:0]    y_live;
    cp_t  [NPT-1:0]    y_all;
    cs_t  [NPT-1:0]    sums;
    cd_t  [NPT-1:0]    sel;
    logic              sel_ovf;
    logic [HW-1:0]     sel_hd;
    cd_t  [NPT-1:0]    out_q;
    logic              ovf_q;
    logic [HW-1:0]     hd_q;
    logic              done_q;

    assign busy = (state == ST_RUN);

    bfly_r4_mac u_mac (
        .clk    (clk),
        .rst    (rst),
        .en     (busy),
        .step   (cnt),
        .xs     (xs_q),
        .tw     (tw_q),
        .y_live (y_live)
    );

    always_comb begin
        y_all[0].re = sext_p(xs_q[0].re);
        y_all[0].im = sext_p(xs_q[0].im);
        for (int k = 0; k < NTW; k++) y_all[k+1] = y_live[k];
    end

    bfly_r4_net u_net (
        .y (y_all),
        .s (sums)
    );

    bfly_r4_sel u_sel (
        .s    (sums),
        .mode (mode_q),
        .o    (sel),
        .ovf  (sel_ovf),
        .hdrm (sel_hd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            xs_q   <= '0;
            tw_q   <= '0;
            mode_q <= GROW2;
            out_q  <= '0;
            ovf_q  <= 1'b0;
            hd_q   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state  <= ST_RUN;
                        cnt    <= '0;
                        mode_q <= grow_e'(mode);
                        for (int i = 0; i < NPT; i++) begin
                            xs_q[i].re <= din_re[i] << pre_shift;
                            xs_q[i].im <= din_im[i] << pre_shift;
                        end
                        for (int k = 0; k < NTW; k++) begin
                            tw_q[k].re <= tw_re[k];
                            tw_q[k].im <= tw_im[k];
                        end
                    end
                end
                default: begin
                    if (cnt == CW'(NCYC - 1)) begin
                        state  <= ST_IDLE;
                        done_q <= 1'b1;
                        out_q  <= sel;
                        ovf_q  <= sel_ovf;
                        hd_q   <= sel_hd;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    always_comb begin
        for (int i = 0; i < NPT; i++) begin
            dout_re[i] = out_q[i].re;
            dout_im[i] = out_q[i].im;
        end
    end

    assign done = done_q;
    assign ovf  = ovf_q;
    assign hdrm = hd_q;

endmodule

// File: rtl/bfly_r4_chk.sv
module bfly_r4_chk
    import bfly_r4_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   start,
    input logic                   busy,
    input logic                   done,
    input logic                   mode_q,
    input logic                   ovf,
    input logic [NPT-1:0][DW-1:0] dout_re,
    input logic [NPT-1:0][DW-1:0] dout_im,
    input logic [HW-1:0]          hdrm
);

    logic [CW:0] run_len;

    always_ff @(posedge clk) begin
        if (rst)       run_len <= '0;
        else if (busy) run_len <= run_len + 1'b1;
        else           run_len <= '0;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!busy && !done && !ovf));

    assert_start_R2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
        done |-> (run_len == (CW+1)'(NCYC)));

    assert_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_no_restart_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && run_len != '0) |-> (run_len <= (CW+1)'(NCYC - 1)));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        (done && mode_q) |-> !ovf);

    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(dout_re) && $stable(dout_im) && $stable(ovf) && $stable(hdrm)));

endmodule

bind bfly_r4_core bfly_r4_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .mode_q  (mode_q),
    .ovf     (ovf),
    .dout_re (dout_re),
    .dout_im (dout_im),
    .hdrm    (hdrm)
);

// File: tb/bfly_r4_core_bench.sv
module bfly_r4_core_bench;
    timeunit 1ns;
    timeprecision 1ps;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic             mode = 1'b0;
    logic [1:0]       pre_shift = 2'd0;
    logic [3:0][15:0] din_re = '0;
    logic [3:0][15:0] din_im = '0;
    logic [2:0][15:0] tw_re = '0;
    logic [2:0][15:0] tw_im = '0;
    logic             busy, done, ovf;
    logic [3:0][15:0] dout_re, dout_im;
    logic [3:0]       hdrm;

    bfly_r4_core u_bfly_r4_core (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .pre_shift(pre_shift),
        .din_re(din_re), .din_im(din_im), .tw_re(tw_re), .tw_im(tw_im),
        .busy(busy), .done(done), .dout_re(dout_re), .dout_im(dout_im),
        .ovf(ovf), .hdrm(hdrm)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        logic [3:0][15:0] ore;
        logic [3:0][15:0] oim;
        logic             ovf;
        logic [3:0]       hd;
        int               t0;
        string            tag;
        logic             md;
    } exp_t;

    exp_t q[$];
    exp_t last;
    int checks = 0;
    int fails = 0;
    int unsigned seed = 32'h1234_5678;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] want);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, want);
        end
    endtask

    function automatic int pr(input int a, input int b);
        int f;
        f = (a * b) >>> 14;
        return f | 1;
    endfunction

    function automatic int sbits(input logic [15:0] v);
        int n = 0;
        bit run = 1;
        for (int i = 14; i >= 0; i--) begin
            if (run && v[i] == v[15]) n++;
            else run = 0;
        end
        return n;
    endfunction

    function automatic exp_t model(input logic md, input logic [1:0] sh);
        exp_t e;
        int xr[4], xi[4], yr[4], yi[4], sr[4], si[4];
        int ar, ai, br, bi, cr, ci, dr, di, wr, wi, lim, sft, hmin;
        for (int i = 0; i < 4; i++) begin
            xr[i] = int'(signed'(16'(din_re[i] << sh)));
            xi[i] = int'(signed'(16'(din_im[i] << sh)));
        end
        yr[0] = xr[0];
        yi[0] = xi[0];
        for (int k = 0; k < 3; k++) begin
            wr = int'(signed'(tw_re[k]));
            wi = int'(signed'(tw_im[k]));
            yr[k+1] = (pr(xr[k+1], wr) - pr(xi[k+1], wi)) >>> 1;
            yi[k+1] = (pr(xr[k+1], wi) + pr(xi[k+1], wr)) >>> 1;
        end
        ar = (yr[0] + yr[2]) >>> 1;  ai = (yi[0] + yi[2]) >>> 1;
        br = (yr[0] - yr[2]) >>> 1;  bi = (yi[0] - yi[2]) >>> 1;
        cr = (yr[1] + yr[3]) >>> 1;  ci = (yi[1] + yi[3]) >>> 1;
        dr = (yr[1] - yr[3]) >>> 1;  di = (yi[1] - yi[3]) >>> 1;
        sr[0] = ar + cr;  si[0] = ai + ci;
        sr[1] = br + di;  si[1] = bi - dr;
        sr[2] = ar - cr;  si[2] = ai - ci;
        sr[3] = br - di;  si[3] = bi + dr;
        sft = md ? 2 : 1;
        lim = md ? 131072 : 65536;
        e.ovf = 1'b0;
        hmin = 15;
        for (int i = 0; i < 4; i++) begin
            e.ore[i] = 16'(sr[i] >>> sft);
            e.oim[i] = 16'(si[i] >>> sft);
            if (sr[i] >= lim || sr[i] < -lim || si[i] >= lim || si[i] < -lim) e.ovf = 1'b1;
            if (sbits(e.ore[i]) < hmin) hmin = sbits(e.ore[i]);
            if (sbits(e.oim[i]) < hmin) hmin = sbits(e.oim[i]);
        end
        e.hd = 4'(hmin);
        e.md = md;
        return e;
    endfunction

    function automatic logic [15:0] rnd(input int drop);
        logic signed [15:0] t;
        seed = seed * 32'd1103515245 + 32'd12345;
        t = seed[30:15];
        return t >>> drop;
    endfunction

    task automatic fill(input int drop);
        for (int i = 0; i < 4; i++) begin
            din_re[i] = rnd(drop);
            din_im[i] = rnd(drop);
        end
        for (int k = 0; k < 3; k++) begin
            tw_re[k] = rnd(0);
            tw_im[k] = rnd(0);
        end
    endtask

    task automatic send(input string tag, input logic md, input logic [1:0] sh);
        exp_t e;
        @(negedge clk);
        mode = md;
        pre_shift = sh;
        start = 1'b1;
        e = model(md, sh);
        e.t0 = cyc;
        e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!done);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && done) begin
            if (q.size() == 0) begin
                chk(1'b0, "R3", "done without a pending start", 64'd1, 64'd0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(cyc - e.t0 == 13, "R2", "done latency", 64'(cyc - e.t0), 64'd13);
                chk(dout_re == e.ore, e.tag, "dout_re", dout_re, e.ore);
                chk(dout_im == e.oim, e.tag, "dout_im", dout_im, e.oim);
                chk(ovf == e.ovf, e.md ? "R9" : "R8", "ovf", 64'(ovf), 64'(e.ovf));
                chk(hdrm == e.hd, "R10", "hdrm", 64'(hdrm), 64'(e.hd));
                last = e;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R1", "busy/done in reset", {busy, done}, 64'd0);
        chk(dout_re == '0 && dout_im == '0, "R1", "outputs in reset", dout_re | dout_im, 64'd0);
        chk(ovf == 1'b0 && hdrm == 4'd0, "R1", "ovf/hdrm in reset", {ovf, hdrm}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R1", "busy/done after reset", {busy, done}, 64'd0);

        // R5: all-zero operands expose the forced product LSB
        send("R5", 1'b0, 2'd0); wait_done();

        // R6: only point 0 non-zero, bypassing the multiplier
        din_re = '0; din_im = '0;
        din_re[0] = 16'd1200; din_im[0] = 16'hFED4;
        tw_re[0] = 16'd12000; tw_im[0] = 16'hA000;
        send("R6", 1'b0, 2'd0); wait_done();

        // R6: one rotated point with a 45-degree twiddle
        din_re = '0; din_im = '0;
        din_re[1] = 16'd1000; din_im[1] = 16'd500;
        tw_re[0] = 16'd23170; tw_im[0] = 16'h A57E;
        send("R6", 1'b1, 2'd0); wait_done();

        // R7: general operands in both growth windows
        for (int n = 0; n < 8; n++) begin
            fill(2);
            send("R7", 1'(n % 2), 2'd0); wait_done();
        end

        // R8 / R9: full-scale operands
        for (int i = 0; i < 4; i++) begin din_re[i] = 16'h7FFF; din_im[i] = 16'h7FFF; end
        for (int k = 0; k < 3; k++) begin tw_re[k] = 16'h7FFF; tw_im[k] = 16'h8001; end
        send("R8", 1'b0, 2'd0); wait_done();
        send("R9", 1'b1, 2'd0); wait_done();
        for (int i = 0; i < 4; i++) begin din_re[i] = 16'h8000; din_im[i] = 16'h7FFF; end
        send("R9", 1'b1, 2'd0); wait_done();
        for (int n = 0; n < 4; n++) begin
            fill(0);
            send("R9", 1'b1, 2'd0); wait_done();
        end

        // R4: pre-shift of data samples
        for (int s = 1; s < 4; s++) begin
            fill(4);
            send("R4", 1'b0, 2'(s)); wait_done();
        end

        // R3: a start during a run is ignored
        fill(3);
        send("R3", 1'b0, 2'd1);
        repeat (3) @(negedge clk);
        fill(1);
        mode = 1'b1;
        pre_shift = 2'd3;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        repeat (15) @(negedge clk);
        chk(busy == 1'b0, "R3", "no second run", 64'(busy), 64'd0);

        // R11: results hold after the strobe
        fill(2);
        send("R11", 1'b0, 2'd0); wait_done();
        fill(0);
        repeat (6) @(negedge clk);
        chk(dout_re == last.ore && dout_im == last.oim, "R11", "held outputs",
            dout_re, last.ore);
        chk(ovf == last.ovf && hdrm == last.hd, "R11", "held flags",
            {ovf, hdrm}, {last.ovf, last.hd});

        repeat (2) @(negedge clk);
        chk(q.size() == 0, "R2", "pending results", 64'(q.size()), 64'd0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R2 watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule